// File: doc/BRIEF.md
# Capture Timer with Edge-Selected Triggers

A 16-bit counter that steps on a prescaled tick and copies its present count into a capture register when a capture event occurs. A small register interface holds the control word, the period, the captured value, the count, a command register (software start, stop, reload, capture), per-event trigger routing and edge selection, and sticky interrupt causes. Four trigger inputs can be routed to any of five events: reload, start, stop, capture and count. Each event has its own edge selector.

After being enabled in capture mode the counter stays idle until a start event arrives. It counts up and wraps from the period value to zero, or counts down and reloads the period after zero. In one-shot operation it halts at the terminal value. Reaching the terminal value gives a one-clock terminal-count pulse, and in up mode also an overflow pulse. Capture edges that fall between two counter ticks are combined by parity, so an odd number captures once and an even number does not capture.

Register map (word addresses): 0 control, 1 period, 2 capture (read-only), 3 count, 4 command, 5 trigger routing, 6 edge select, 7 interrupt causes.

Top module: `capture_timer`

## Requirements
- R1: After reset, control and count read 0, capture reads 0, period reads 16'hFFFF, edge select reads 10'h3FF (every event off), interrupt causes read 0, and tc_o, ov_o and irq_o are low.
- R2: The counter advances only while control bit 0 (enable) is 1 and the mode field at control bits [26:24] is 3'b010. After enabling it holds its count until a start event. Command writes are ignored while it is not active.
- R3: With direction field control[17:16] other than 2'b01, the count steps by one per tick and goes from the period value to 0. tc_o and ov_o pulse high for one clock in the cycle the count becomes equal to the period.
- R4: With control[17:16] = 2'b01, the count steps down by one per tick and goes from 0 to the period value. tc_o pulses when the count becomes 0, and ov_o stays low. A reload event loads the period in down mode and 0 in up mode, and it also starts the counter.
- R5: With control bit 18 (one-shot) set, the counter stops on reaching the terminal value and keeps that value.
- R6: Ticks occur once every 2^P clocks while active, where P is control[10:8].
- R7: A capture copies the count held before the tick into the capture register and sets interrupt cause bit 1. Capture comes from command bit 1 or from a selected trigger edge. Edge-select codes: 2'b00 rising, 2'b01 falling, 2'b10 both, 2'b11 none. Register 6 holds 2-bit fields at [1:0] reload, [3:2] start, [5:4] stop, [7:6] capture and [9:8] count. Register 5 holds the trigger-input index per event at the same positions.
- R8: Capture edges gathered since the previous tick capture once if their number is odd and not at all if it is even.
- R9: Command bits [0] start, [2] stop and [3] reload, and routed trigger edges, act on the next tick. When events coincide, stop beats reload, and reload beats start and stepping. If the count edge select is not 2'b11, the counter steps only on ticks that follow a count edge. Otherwise it steps on every tick.
- R10: Writes to routing, edge select and count are ignored while enable is 1.
- R11: Interrupt causes (bit 0 terminal count, bit 1 capture) are sticky and cleared by writing 1. Both are set when the two causes occur on the same tick. irq_o is high while a cause is set and its enable is set: control bit 1 for terminal count, bit 2 for capture.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 3 | Register word address |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data, combinational from reg_addr |
| trig_i | input | 4 | Hardware trigger inputs |
| tc_o | output | 1 | Terminal-count pulse |
| ov_o | output | 1 | Overflow pulse (up mode) |
| irq_o | output | 1 | Interrupt request |

## Verification
Every effect is registered on the tick edge where its event is consumed. With a prescale of 0, a command written at an edge starts the counter at that edge, the first step is seen one clock later, and tc_o is due in the same cycle as the count that equals the terminal value. The bench drives inputs at falling edges and reads registers and pulses just after the next falling edge, so each check counts whole clocks from the edge where the stimulus was registered. For prescaled runs, where the tick phase is not visible at the ports, the bench first finds a tick by watching the count change. It then places trigger edges inside the following window of 2^P clocks and checks the capture register after the next observed change.

// File: rtl/capture_timer.sv
module capture_timer #(
  parameter int CNT_W = 16,
  parameter int NTRIG = 4,
  parameter int PS_W  = 3
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             reg_we,
  input  logic [2:0]       reg_addr,
  input  logic [31:0]      reg_wdata,
  output logic [31:0]      reg_rdata,
  input  logic [NTRIG-1:0] trig_i,
  output logic             tc_o,
  output logic             ov_o,
  output logic             irq_o
);
  localparam int SEL_W = (NTRIG > 1) ? $clog2(NTRIG) : 1;
  localparam int NEV   = 5;
  localparam int DIV_W = (1 << PS_W) - 1;
  localparam int E_RLD = 0, E_STA = 1, E_STP = 2, E_CAP = 3, E_CNT = 4;
  localparam logic [2:0] MODE_CAPTURE = 3'b010;

  logic             en_q, tcie_q, ccie_q, os_q;
  logic [PS_W-1:0]  ps_q;
  logic [1:0]       dir_q;
  logic [2:0]       mode_q;
  logic [CNT_W-1:0] period_q, count_q, cap_q;
  logic [NEV*SEL_W-1:0] tsel_q;
  logic [2*NEV-1:0] tedge_q;
  logic [1:0]       intr_q;
  logic [NTRIG-1:0] trig_q;
  logic             running_q, tc_q, ov_q;
  logic [NEV-1:0]   pend_q, pend_n, hw_ev, sw_ev, ev_or;
  logic [DIV_W-1:0] presc_q, ps_mask;

  logic active, tick, cmd_wr, cnt_up, cnt_free;
  logic do_stop, do_reload, do_start, do_step, do_cap, hit_term;
  logic [CNT_W-1:0] step_val;
  logic [1:0] intr_set, intr_clr;
  logic unused_wdata;

  assign unused_wdata = ^reg_wdata;

  for (genvar e = 0; e < NEV; e++) begin : g_ev
    logic [SEL_W-1:0] src;
    logic [1:0] es;
    logic cur, prv, rise, fall;
    assign src  = tsel_q[e*SEL_W +: SEL_W];
    assign es   = tedge_q[2*e +: 2];
    assign cur  = trig_i[src];
    assign prv  = trig_q[src];
    assign rise = cur & ~prv;
    assign fall = ~cur & prv;
    assign hw_ev[e] = (es == 2'b00) ? rise :
                      (es == 2'b01) ? fall :
                      (es == 2'b10) ? (rise | fall) : 1'b0;
  end

  assign active  = en_q && (mode_q == MODE_CAPTURE);
  assign ps_mask = ~({DIV_W{1'b1}} << ps_q);
  assign tick    = active && (presc_q == ps_mask);
  assign cmd_wr  = active && reg_we && (reg_addr == 3'd4);
  assign sw_ev   = {1'b0, reg_wdata[1], reg_wdata[2], reg_wdata[0], reg_wdata[3]} & {NEV{cmd_wr}};
  assign ev_or   = pend_q | hw_ev | sw_ev;
  assign pend_n  = {ev_or[E_CNT], pend_q[E_CAP] ^ hw_ev[E_CAP] ^ sw_ev[E_CAP], ev_or[E_STP:E_RLD]};

  assign cnt_up   = (dir_q != 2'b01);
  assign cnt_free = (tedge_q[2*E_CNT +: 2] == 2'b11);
  assign do_stop   = pend_n[E_STP];
  assign do_reload = !do_stop && pend_n[E_RLD];
  assign do_start  = !do_stop && !do_reload && pend_n[E_STA];
  assign do_step   = !do_stop && !do_reload && running_q && (cnt_free || pend_n[E_CNT]);
  assign do_cap    = pend_n[E_CAP];

  assign step_val = cnt_up ? ((count_q >= period_q) ? '0 : count_q + CNT_W'(1))
                           : ((count_q == '0) ? period_q : count_q - CNT_W'(1));
  assign hit_term = cnt_up ? (step_val == period_q) : (step_val == '0);

  assign intr_set = {tick && do_cap, tick && do_step && hit_term};
  assign intr_clr = (reg_we && reg_addr == 3'd7) ? reg_wdata[1:0] : 2'b00;

  assign tc_o  = tc_q;
  assign ov_o  = ov_q;
  assign irq_o = |(intr_q & {ccie_q, tcie_q});

  always_comb begin
    reg_rdata = '0;
    case (reg_addr)
      3'd0: reg_rdata = {5'b0, mode_q, 5'b0, os_q, dir_q, {(8-PS_W){1'b0}}, ps_q,
                         5'b0, ccie_q, tcie_q, en_q};
      3'd1: reg_rdata = {{(32-CNT_W){1'b0}}, period_q};
      3'd2: reg_rdata = {{(32-CNT_W){1'b0}}, cap_q};
      3'd3: reg_rdata = {{(32-CNT_W){1'b0}}, count_q};
      3'd5: reg_rdata = {{(32-NEV*SEL_W){1'b0}}, tsel_q};
      3'd6: reg_rdata = {{(32-2*NEV){1'b0}}, tedge_q};
      3'd7: reg_rdata = {30'b0, intr_q};
      default: reg_rdata = '0;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      en_q <= 1'b0; tcie_q <= 1'b0; ccie_q <= 1'b0; os_q <= 1'b0;
      ps_q <= '0; dir_q <= '0; mode_q <= '0;
      period_q <= '1; count_q <= '0; cap_q <= '0;
      tsel_q <= '0; tedge_q <= '1; intr_q <= '0; trig_q <= '0;
      running_q <= 1'b0; tc_q <= 1'b0; ov_q <= 1'b0;
      pend_q <= '0; presc_q <= '0;
    end else begin
      trig_q <= trig_i;
      tc_q   <= 1'b0;
      ov_q   <= 1'b0;
      intr_q <= (intr_q & ~intr_clr) | intr_set;

      if (reg_we) begin
        case (reg_addr)
          3'd0: begin
            en_q   <= reg_wdata[0];
            tcie_q <= reg_wdata[1];
            ccie_q <= reg_wdata[2];
            ps_q   <= reg_wdata[8 +: PS_W];
            dir_q  <= reg_wdata[17:16];
            os_q   <= reg_wdata[18];
            mode_q <= reg_wdata[26:24];
          end
          3'd1: period_q <= reg_wdata[CNT_W-1:0];
          3'd3: if (!en_q) count_q <= reg_wdata[CNT_W-1:0];
          3'd5: if (!en_q) tsel_q <= reg_wdata[NEV*SEL_W-1:0];
          3'd6: if (!en_q) tedge_q <= reg_wdata[2*NEV-1:0];
          default: ;
        endcase
      end

      if (!active) begin
        running_q <= 1'b0;
        pend_q    <= '0;
        presc_q   <= '0;
      end else if (!tick) begin
        pend_q  <= pend_n;
        presc_q <= presc_q + DIV_W'(1);
      end else begin
        pend_q  <= '0;
        presc_q <= '0;
        if (do_cap) cap_q <= count_q;
        if (do_stop) begin
          running_q <= 1'b0;
        end else if (do_reload) begin
          count_q   <= cnt_up ? '0 : period_q;
          running_q <= 1'b1;
        end else begin
          if (do_start) running_q <= 1'b1;
          if (do_step) begin
            count_q <= step_val;
            if (hit_term) begin
              tc_q <= 1'b1;
              ov_q <= cnt_up;
              if (os_q) running_q <= 1'b0;
            end
          end
        end
      end
    end
  end
endmodule

// File: rtl/capture_timer_chk.sv
module capture_timer_chk #(
  parameter int CNT_W = 16
) (
  input logic             clk,
  input logic             rst_n,
  input logic             tc_o,
  input logic             ov_o,
  input logic             active,
  input logic             running_q,
  input logic             os_q,
  input logic             cnt_up,
  input logic             tick,
  input logic [CNT_W-1:0] count_q,
  input logic [CNT_W-1:0] period_q,
  input logic [CNT_W-1:0] cap_q,
  input logic [1:0]       intr_q,
  input logic             reg_we,
  input logic [2:0]       reg_addr,
  input logic [31:0]      reg_wdata
);
  a_r3_tc_at_terminal: assert property (@(posedge clk) disable iff (!rst_n)
    (tc_o && !$past(reg_we)) |->
      (($past(cnt_up) && count_q == period_q) || (!$past(cnt_up) && count_q == '0)));

  a_r4_ov_needs_tc: assert property (@(posedge clk) disable iff (!rst_n)
    ov_o |-> tc_o);

  a_r5_oneshot_halts: assert property (@(posedge clk) disable iff (!rst_n)
    (tc_o && os_q && !$past(reg_we)) |-> !running_q);

  a_r2_frozen_when_idle: assert property (@(posedge clk) disable iff (!rst_n)
    (!active && !(reg_we && reg_addr == 3'd3)) |=> $stable(count_q));

  a_r7_capture_on_tick: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(cap_q) |-> $past(tick));

  a_r11_tc_cause_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    (intr_q[0] && !(reg_we && reg_addr == 3'd7 && reg_wdata[0])) |=> intr_q[0]);
endmodule

bind capture_timer capture_timer_chk #(.CNT_W(CNT_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .tc_o(tc_o), .ov_o(ov_o), .active(active),
  .running_q(running_q), .os_q(os_q), .cnt_up(cnt_up), .tick(tick),
  .count_q(count_q), .period_q(period_q), .cap_q(cap_q), .intr_q(intr_q),
  .reg_we(reg_we), .reg_addr(reg_addr), .reg_wdata(reg_wdata)
);

// File: tb/capture_timer_bench.sv
`timescale 1ns/1ps
module capture_timer_bench;
  logic clk = 1'b0, rst_n = 1'b0, reg_we = 1'b0;
  logic [2:0] reg_addr = '0;
  logic [31:0] reg_wdata = '0, reg_rdata;
  logic [3:0] trig = '0;
  logic tc_o, ov_o, irq_o;
  int checks = 0, errors = 0;

  localparam logic [2:0] A_CTRL = 0, A_PER = 1, A_CAP = 2, A_CNT = 3,
                         A_CMD = 4, A_SEL = 5, A_EDGE = 6, A_INT = 7;

  capture_timer u_capture_timer (
    .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .trig_i(trig),
    .tc_o(tc_o), .ov_o(ov_o), .irq_o(irq_o)
  );

  always #2 clk = ~clk;

  function automatic logic [31:0] mk_ctrl(bit en, bit tcie, bit ccie, int ps,
                                          int dir, bit os, int mode);
    return {5'b0, 3'(mode), 5'b0, os, 2'(dir), 5'b0, 3'(ps), 5'b0, ccie, tcie, en};
  endfunction

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic wr(logic [2:0] a, logic [31:0] d);
    @(negedge clk);
    reg_we = 1'b1; reg_addr = a; reg_wdata = d;
    @(posedge clk); #1;
    reg_we = 1'b0;
  endtask

  task automatic rd(logic [2:0] a, output logic [31:0] v);
    reg_addr = a; #1; v = reg_rdata;
  endtask

  task automatic setup(logic [31:0] ctrl, logic [31:0] per, logic [31:0] sel, logic [31:0] edg);
    wr(A_CTRL, ctrl & ~32'h1);
    wr(A_CNT, 0);
    wr(A_PER, per);
    wr(A_SEL, sel);
    wr(A_EDGE, edg);
    wr(A_INT, 3);
    wr(A_CTRL, ctrl | 32'h1);
  endtask

  task automatic wait_change(output logic [31:0] now);
    logic [31:0] c0, c;
    rd(A_CNT, c0);
    for (int i = 0; i < 60; i++) begin
      @(negedge clk); rd(A_CNT, c);
      if (c != c0) break;
    end
    now = c;
  endtask

  task automatic t_reset();
    logic [31:0] v;
    rd(A_CTRL, v); check("R1 ctrl", v, 0);
    rd(A_PER, v);  check("R1 period", v, 32'hFFFF);
    rd(A_CNT, v);  check("R1 count", v, 0);
    rd(A_CAP, v);  check("R1 capture", v, 0);
    rd(A_EDGE, v); check("R1 edge", v, 32'h3FF);
    rd(A_INT, v);  check("R1 intr", v, 0);
    check("R1 outputs", {tc_o, ov_o, irq_o}, 0);
  endtask

  task automatic t_idle();
    logic [31:0] v;
    setup(mk_ctrl(1, 0, 0, 0, 0, 0, 0), 100, 0, 32'h3FF);
    wr(A_CMD, 1);
    repeat (5) @(negedge clk);
    rd(A_CNT, v); check("R2 wrong mode stays idle", v, 0);
    setup(mk_ctrl(1, 0, 0, 0, 0, 0, 2), 100, 0, 32'h3FF);
    repeat (5) @(negedge clk);
    rd(A_CNT, v); check("R2 idle before start", v, 0);
    rd(A_CTRL, v); check("R2 ctrl readback", v, mk_ctrl(1, 0, 0, 0, 0, 0, 2));
    wr(A_CMD, 1);
    repeat (3) @(negedge clk);
    rd(A_CNT, v); check("R2 runs after start", v, 2);
  endtask

  task automatic t_up();
    logic [31:0] v;
    setup(mk_ctrl(1, 0, 0, 0, 0, 0, 2), 3, 0, 32'h3FF);
    wr(A_CMD, 1);
    for (int k = 0; k < 8; k++) begin
      @(negedge clk); rd(A_CNT, v);
      check("R3 up count", v, k % 4);
      check("R3 tc/ov pulse", {tc_o, ov_o}, (k % 4 == 3) ? 2'b11 : 2'b00);
    end
  endtask

  task automatic t_down();
    logic [31:0] v;
    int exp_seq[6] = '{3, 2, 1, 0, 3, 2};
    setup(mk_ctrl(1, 0, 0, 0, 1, 0, 2), 3, 0, 32'h3FF);
    wr(A_CMD, 8);
    for (int k = 0; k < 6; k++) begin
      if (k > 0) @(negedge clk);
      rd(A_CNT, v);
      check("R4 down count", v, exp_seq[k]);
      check("R4 tc only", {tc_o, ov_o}, (exp_seq[k] == 0 && k > 0) ? 2'b10 : 2'b00);
    end
  endtask

  task automatic t_oneshot();
    logic [31:0] v;
    setup(mk_ctrl(1, 0, 0, 0, 0, 1, 2), 2, 0, 32'h3FF);
    wr(A_CMD, 1);
    repeat (2) @(negedge clk);
    @(negedge clk); rd(A_CNT, v); check("R5 reaches terminal", v, 2);
    check("R5 tc", tc_o, 1);
    repeat (5) @(negedge clk);
    rd(A_CNT, v); check("R5 holds", v, 2);
  endtask

  task automatic t_presc();
    logic [31:0] v, prev;
    int last, bad, changes;
    setup(mk_ctrl(1, 0, 0, 2, 0, 0, 2), 32'hFFFF, 0, 32'h3FF);
    wr(A_CMD, 1);
    last = -1; bad = 0; changes = 0;
    rd(A_CNT, prev);
    for (int i = 0; i < 40; i++) begin
      @(negedge clk); rd(A_CNT, v);
      if (v != prev) begin
        if (v != prev + 1) bad++;
        if (last >= 0 && i - last != 4) bad++;
        last = i; changes++;
        prev = v;
      end
    end
    check("R6 step spacing", bad, 0);
    check("R6 step count ok", (changes >= 9) ? 1 : 0, 1);
  endtask

  task automatic t_capture();
    logic [31:0] v, c, cap0;
    setup(mk_ctrl(1, 0, 0, 0, 0, 0, 2), 32'hFFFF, 32'h080, 32'h37F);
    wr(A_CMD, 1);
    repeat (3) @(negedge clk);
    rd(A_CNT, c);
    wr(A_CMD, 2);
    rd(A_CAP, v); check("R7 sw capture", v, c + 1);
    rd(A_INT, v); check("R7 cc cause", v[1], 1);
    rd(A_CAP, cap0);
    @(negedge clk); trig[2] = 1'b1;
    repeat (2) @(negedge clk);
    rd(A_CAP, v); check("R7 rising ignored", v, cap0);
    rd(A_CNT, c);
    trig[2] = 1'b0;
    @(negedge clk); rd(A_CAP, v); check("R7 falling captures", v, c);
  endtask

  task automatic t_parity();
    logic [31:0] v, c, cap0;
    setup(mk_ctrl(1, 0, 0, 3, 0, 0, 2), 32'hFFFF, 32'h0C0, 32'h33F);
    wr(A_CMD, 1);
    wr(A_EDGE, 0);
    rd(A_EDGE, v); check("R10 edge locked", v, 32'h33F);
    wr(A_SEL, 0);
    rd(A_SEL, v); check("R10 routing locked", v, 32'h0C0);
    wr(A_CNT, 32'h1234);
    rd(A_CNT, v); check("R10 count locked", (v == 32'h1234) ? 1 : 0, 0);
    wait_change(c);
    rd(A_CAP, cap0);
    for (int i = 0; i < 2; i++) begin
      trig[3] = 1'b1; @(negedge clk); trig[3] = 1'b0; @(negedge clk);
    end
    wait_change(c);
    rd(A_CAP, v); check("R8 even edges no capture", v, cap0);
    for (int i = 0; i < 3; i++) begin
      trig[3] = 1'b1; @(negedge clk); trig[3] = 1'b0; @(negedge clk);
    end
    wait_change(v);
    rd(A_CAP, v); check("R8 odd edges capture once", v, c);
  endtask

  task automatic t_hw_ctrl();
    logic [31:0] v;
    setup(mk_ctrl(1, 0, 0, 0, 0, 0, 2), 32'hFFFF, 32'h010, 32'h3C3);
    repeat (3) @(negedge clk);
    rd(A_CNT, v); check("R9 waits for hw start", v, 0);
    trig[0] = 1'b1;
    @(negedge clk); trig[0] = 1'b0;
    repeat (4) @(negedge clk);
    rd(A_CNT, v); check("R9 hw start", v, 4);
    trig[1] = 1'b1;
    @(negedge clk); trig[1] = 1'b0;
    repeat (4) @(negedge clk);
    rd(A_CNT, v); check("R9 hw stop", v, 4);
    setup(mk_ctrl(1, 0, 0, 0, 0, 0, 2), 32'hFFFF, 32'h200, 32'h2FF);
    wr(A_CMD, 1);
    repeat (3) @(negedge clk);
    rd(A_CNT, v); check("R9 gated count idle", v, 0);
    for (int i = 0; i < 3; i++) begin
      trig[2] = ~trig[2]; @(negedge clk); @(negedge clk);
    end
    rd(A_CNT, v); check("R9 count per edge", v, 3);
    trig[2] = 1'b0;
  endtask

  task automatic t_irq();
    logic [31:0] v;
    setup(mk_ctrl(1, 1, 0, 0, 0, 1, 2), 3, 0, 32'h3FF);
    wr(A_CMD, 1);
    @(negedge clk); @(negedge clk);
    wr(A_CMD, 2);
    rd(A_INT, v); check("R11 both causes", v, 3);
    rd(A_CAP, v); check("R11 capture value", v, 2);
    check("R11 irq tc enabled", irq_o, 1);
    wr(A_INT, 1);
    rd(A_INT, v); check("R11 w1c tc", v, 2);
    check("R11 irq masked cc", irq_o, 0);
    repeat (3) @(negedge clk);
    rd(A_INT, v); check("R11 cc sticky", v, 2);
    wr(A_CTRL, mk_ctrl(1, 1, 1, 0, 0, 1, 2));
    @(negedge clk); check("R11 irq cc enabled", irq_o, 1);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    checks++; errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_idle();
    t_up();
    t_down();
    t_oneshot();
    t_presc();
    t_capture();
    t_parity();
    t_hw_ctrl();
    t_irq();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule